// File: doc/BRIEF.md
# Exception Return Status Unstacker

This block performs the status-word update for the two return instructions of a processor core: return from an ordinary exception and return from a non-maskable interrupt. On entry to an exception the core pushed mode fields up the status word. On return this block shifts the low field down by ten places to pop one level. The two top bits stay where they are. The two bits just below them come back as zero.

After the shift the block applies two fixed flag rules. The pending flag is set unless the return flag was set in the word before the shift. A return from a non-maskable interrupt also forces the interrupt-mask flag. When the shifted word selects user mode, the block swaps the stack pointers. The live stack pointer is handed out as the saved kernel stack pointer, and the saved user stack pointer becomes the live one.

The core pulses a strobe together with the current status word, the live stack pointer, the saved user stack pointer and the return kind. One cycle later the block pulses done with all results registered. The results then hold until the next strobe. Reloading the program counter and any memory traffic belong to other blocks.

Top module: `eru_unstacker`

## Requirements
- R1: While reset is asserted, and directly after it, `status_o`, `sp_o` and `ksp_o` are zero and `done_o` is low.
- R2: Ignoring the flag rules of R3 and R4, the new status is (old AND 0xC000_0000) OR ((old AND 0x0FFF_FFFF) >> 10). Bits 29:28 and 27:18 of the result are therefore zero.
- R3: If bit 8 of the old status (the return flag) is 0, bit 7 of the new status (the pending flag) is 1. If bit 8 of the old status is 1, bit 7 of the new status is the shifted value, which is old bit 17.
- R4: When `kind_i` is 1 (return from non-maskable interrupt), bit 9 of the new status (the interrupt-mask flag) is 1.
- R5: When `kind_i` is 0 (return from exception), bit 9 of the new status is the shifted value, which is old bit 19, and is never forced.
- R6: If bit 8 of the new status (the user flag) is 1, `ksp_o` takes `sp_i` and `sp_o` takes `usp_i`.
- R7: If bit 8 of the new status is 0, `sp_o` takes `sp_i` and `ksp_o` keeps its previous value.
- R8: `done_o` is high for exactly the one cycle after a cycle with `go_i` high, and the new results appear in that same cycle. Without `go_i`, all outputs hold their values whatever the other inputs do.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| go_i | input | 1 | Strobe that starts one return update |
| kind_i | input | 1 | Return kind: 0 exception, 1 non-maskable interrupt |
| status_i | input | 32 | Current status word |
| sp_i | input | 32 | Current stack pointer |
| usp_i | input | 32 | Saved user stack pointer |
| status_o | output | 32 | Unstacked status word |
| sp_o | output | 32 | New stack pointer |
| ksp_o | output | 32 | Saved kernel stack pointer |
| done_o | output | 1 | One-cycle completion pulse |

## Verification
The bench builds the block with its default parameters: a 32-bit word, a 10-place shift, two kept top bits, and the return, user, pending and mask flags at bits 8, 8, 7 and 9. These values put every flag interaction within reach of a few hand-chosen words. A return flag set in the old word suppresses the forced pending bit. An old bit 18 lands on the user flag and triggers the stack swap. An old bit 19 lands on the mask flag, which tells forcing apart from plain shifting. Set bits in 29:28 must vanish. Directed phases then hold the strobe low while the other inputs change, and check a run of returns without user mode so that the kept kernel stack pointer is visible.

// File: rtl/eru_pkg.sv
package eru_pkg;
  // Default geometry of the status word.
  localparam int ERU_W     = 32;  // status and pointer width
  localparam int ERU_KEEP  = 2;   // top bits left in place
  localparam int ERU_GAP   = 2;   // bits below the kept ones, cleared
  localparam int ERU_SHIFT = 10;  // places popped per return

  // Default flag positions.
  localparam int ERU_R_POS = 8;   // return flag, read before the shift
  localparam int ERU_P_POS = 7;   // pending flag, in the result
  localparam int ERU_U_POS = 8;   // user flag, in the result
  localparam int ERU_M_POS = 9;   // interrupt-mask flag, in the result

  typedef enum logic {
    RET_EXC = 1'b0,
    RET_NMI = 1'b1
  } ret_kind_e;
endpackage

// File: rtl/eru_status_shift.sv
module eru_status_shift #(
  parameter int W     = eru_pkg::ERU_W,
  parameter int KEEP  = eru_pkg::ERU_KEEP,
  parameter int GAP   = eru_pkg::ERU_GAP,
  parameter int SHIFT = eru_pkg::ERU_SHIFT,
  parameter int R_POS = eru_pkg::ERU_R_POS,
  parameter int P_POS = eru_pkg::ERU_P_POS,
  parameter int M_POS = eru_pkg::ERU_M_POS
) (
  input  logic [W-1:0] old_i,
  input  logic         is_nmi_i,
  output logic [W-1:0] new_o,
  output logic         r_was_set_o
);
  localparam int FIELD = W - KEEP - GAP;
  localparam logic [W-1:0] KEEP_MASK = {{KEEP{1'b1}}, {(W-KEEP){1'b0}}};

  function automatic logic [W-1:0] pop_field(input logic [W-1:0] old);
    logic [W-1:0] low;
    low = {{(KEEP+GAP){1'b0}}, old[FIELD-1:0]};
    return (old & KEEP_MASK) | (low >> SHIFT);
  endfunction

  logic [W-1:0] shifted;

  always_comb begin
    shifted = pop_field(old_i);
    new_o   = shifted;
    if (!old_i[R_POS]) new_o[P_POS] = 1'b1;
    if (is_nmi_i)      new_o[M_POS] = 1'b1;
  end

  assign r_was_set_o = old_i[R_POS];
endmodule

// File: rtl/eru_stack_swap.sv
module eru_stack_swap #(
  parameter int W     = eru_pkg::ERU_W,
  parameter int U_POS = eru_pkg::ERU_U_POS
) (
  input  logic [W-1:0] new_status_i,
  input  logic [W-1:0] sp_i,
  input  logic [W-1:0] usp_i,
  output logic         to_user_o,
  output logic [W-1:0] sp_next_o
);
  assign to_user_o = new_status_i[U_POS];
  assign sp_next_o = to_user_o ? usp_i : sp_i;
endmodule

// File: rtl/eru_unstacker.sv
module eru_unstacker
  import eru_pkg::*;
#(
  parameter int W     = ERU_W,
  parameter int KEEP  = ERU_KEEP,
  parameter int GAP   = ERU_GAP,
  parameter int SHIFT = ERU_SHIFT,
  parameter int R_POS = ERU_R_POS,
  parameter int P_POS = ERU_P_POS,
  parameter int U_POS = ERU_U_POS,
  parameter int M_POS = ERU_M_POS
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         go_i,
  input  logic         kind_i,
  input  logic [W-1:0] status_i,
  input  logic [W-1:0] sp_i,
  input  logic [W-1:0] usp_i,
  output logic [W-1:0] status_o,
  output logic [W-1:0] sp_o,
  output logic [W-1:0] ksp_o,
  output logic         done_o
);
  localparam int GAP_LO = W - KEEP - GAP;

  // Named internal events.
  logic [W-1:0] status_next;
  logic         r_was_set;
  logic         to_user;
  logic [W-1:0] sp_next;
  logic         is_nmi;

  assign is_nmi = (ret_kind_e'(kind_i) == RET_NMI);

  eru_status_shift #(
    .W(W), .KEEP(KEEP), .GAP(GAP), .SHIFT(SHIFT),
    .R_POS(R_POS), .P_POS(P_POS), .M_POS(M_POS)
  ) u_shift (
    .old_i       (status_i),
    .is_nmi_i    (is_nmi),
    .new_o       (status_next),
    .r_was_set_o (r_was_set)
  );

  eru_stack_swap #(.W(W), .U_POS(U_POS)) u_swap (
    .new_status_i (status_next),
    .sp_i         (sp_i),
    .usp_i        (usp_i),
    .to_user_o    (to_user),
    .sp_next_o    (sp_next)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      status_o <= '0;
      sp_o     <= '0;
      ksp_o    <= '0;
      done_o   <= 1'b0;
    end else begin
      done_o <= go_i;
      if (go_i) begin
        status_o <= status_next;
        sp_o     <= sp_next;
        if (to_user) ksp_o <= sp_i;
      end
    end
  end

  // Checks beside the logic they guard.
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    go_i |=> done_o); // R8
  AST_NO_SPURIOUS_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    !go_i |=> !done_o); // R8
  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !go_i |=> ($stable(status_o) && $stable(sp_o) && $stable(ksp_o))); // R8
  AST_GAP_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (status_o[GAP_LO +: GAP] == '0)); // R2
  AST_PENDING_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (go_i && !r_was_set) |=> status_o[P_POS]); // R3
  AST_NMI_MASK: assert property (@(posedge clk) disable iff (!rst_n)
    (go_i && is_nmi) |=> status_o[M_POS]); // R4
  AST_EXC_MASK: assert property (@(posedge clk) disable iff (!rst_n)
    (go_i && !is_nmi) |=> (status_o[M_POS] == $past(status_i[M_POS+SHIFT]))); // R5
  AST_USER_SWAP: assert property (@(posedge clk) disable iff (!rst_n)
    (go_i && to_user) |=> ((sp_o == $past(usp_i)) && (ksp_o == $past(sp_i)))); // R6
  AST_KERNEL_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    (go_i && !to_user) |=> ((sp_o == $past(sp_i)) && $stable(ksp_o))); // R7
endmodule

// File: tb/eru_unstacker_bench.sv
`timescale 1ns/1ps
module eru_unstacker_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        go_i = 1'b0;
  logic        kind_i = 1'b0;
  logic [31:0] status_i = '0, sp_i = '0, usp_i = '0;
  logic [31:0] status_o, sp_o, ksp_o;
  logic        done_o;

  int vectors = 0;
  int miscompares = 0;
  bit finished = 1'b0;
  logic [31:0] model_ksp = '0;

  always #4 clk = ~clk;  // 125 MHz

  eru_unstacker u_eru_unstacker (
    .clk(clk), .rst_n(rst_n), .go_i(go_i), .kind_i(kind_i),
    .status_i(status_i), .sp_i(sp_i), .usp_i(usp_i),
    .status_o(status_o), .sp_o(sp_o), .ksp_o(ksp_o), .done_o(done_o)
  );

  localparam int NV = 10;
  localparam logic [31:0] V_ST [NV] = '{
    32'h0000_0000, 32'hFFFF_FFFF, 32'h0004_0000, 32'h0000_0100,
    32'h3000_0000, 32'h8008_0100, 32'h4004_0100, 32'h1234_5678,
    32'h0002_0100, 32'hC00A_0000 };
  localparam logic V_KIND [NV] = '{
    1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1 };

  // Expected status restated by slicing: kept top, zero gap, zero fill, field.
  function automatic logic [31:0] want_status(input logic [31:0] old, input logic k);
    logic [31:0] e;
    e = {old[31:30], 2'b00, 10'b0, old[27:10]};
    if (old[8] == 1'b0) e[7] = 1'b1;
    if (k) e[9] = 1'b1;
    return e;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic run_one(input logic [31:0] st, input logic k,
                         input logic [31:0] sp, input logic [31:0] usp);
    logic [31:0] es;
    es = want_status(st, k);
    @(negedge clk);
    status_i = st; kind_i = k; sp_i = sp; usp_i = usp; go_i = 1'b1;
    @(negedge clk);
    go_i = 1'b0;
    check("R2/R3/R4/R5 status", status_o, es);
    check("R8 done pulse", {31'b0, done_o}, 32'd1);
    if (es[8]) begin
      check("R6 sp from usp", sp_o, usp);
      check("R6 ksp from sp", ksp_o, sp);
      model_ksp = sp;
    end else begin
      check("R7 sp kept", sp_o, sp);
      check("R7 ksp held", ksp_o, model_ksp);
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      miscompares++;
      vectors++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset values
    check("R1 status", status_o, 32'h0);
    check("R1 sp", sp_o, 32'h0);
    check("R1 ksp", ksp_o, 32'h0);
    check("R1 done", {31'b0, done_o}, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 after release", status_o | sp_o | ksp_o, 32'h0);

    // Table walk
    for (int i = 0; i < NV; i++)
      run_one(V_ST[i], V_KIND[i], 32'h1000_0000 + i * 32'h10, 32'hA000_0000 + i);

    // R8: done drops and outputs hold while inputs change without strobe
    begin
      logic [31:0] hs, hp, hk;
      hs = status_o; hp = sp_o; hk = ksp_o;
      for (int j = 0; j < 4; j++) begin
        status_i = 32'hFFFF_FFFF ^ j; sp_i = 32'h5555_0000 + j; usp_i = ~sp_i; kind_i = j[0];
        @(negedge clk);
        check("R8 done low", {31'b0, done_o}, 32'h0);
        check("R8 status hold", status_o, hs);
        check("R8 sp hold", sp_o, hp);
        check("R8 ksp hold", ksp_o, hk);
      end
    end

    // R7: consecutive kernel returns keep ksp; R5 plain shift of bit 19
    run_one(32'h0008_0000, 1'b0, 32'h2222_0000, 32'h3333_0000);
    run_one(32'h0000_0000, 1'b0, 32'h2222_0004, 32'h3333_0004);
    // R3: return flag set with bit 17 clear leaves pending clear
    run_one(32'h0000_0100, 1'b0, 32'h4444_0000, 32'h5555_0000);
    check("R3 pending clear", {31'b0, status_o[7]}, 32'h0);
    // R4 vs R5 on the same word
    run_one(32'h0000_0100, 1'b1, 32'h4444_0010, 32'h5555_0010);
    check("R4 mask forced", {31'b0, status_o[9]}, 32'h1);
    // R2: gap bits cleared from all-ones field
    run_one(32'h3FFF_FFFF, 1'b0, 32'h6666_0000, 32'h7777_0000);
    check("R2 gap zero", {30'b0, status_o[29:28]}, 32'h0);
    // R6: back-to-back strobes
    @(negedge clk);
    status_i = 32'h0004_0000; kind_i = 1'b0; sp_i = 32'h8888_0000; usp_i = 32'h9999_0000; go_i = 1'b1;
    @(negedge clk);
    sp_i = 32'h8888_0100; usp_i = 32'h9999_0100;
    @(negedge clk);
    go_i = 1'b0;
    check("R6 second sp", sp_o, 32'h9999_0100);
    check("R6 second ksp", ksp_o, 32'h8888_0100);
    check("R8 done after run", {31'b0, done_o}, 32'h1);

    // R1: reset mid-run clears results
    rst_n = 1'b0;
    @(negedge clk);
    check("R1 re-reset", status_o | sp_o | ksp_o | {31'b0, done_o}, 32'h0);

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule